// File: doc/BRIEF.md
# Latched Alarm Interrupt Register Unit

This unit collects the alarm conditions of a two-channel line interface and turns them into host-readable status and one active-low interrupt. Each channel watches a loss-of-signal level, an alarm-indication level, bipolar-violation pulses and waveform-overflow pulses. The shared clock-loss flags and the reset event are also watched. Level conditions are caught on their rising edge and pulses on any cycle they are high. Each caught condition sets a sticky bit that holds until the host reads that channel's status register.

Each channel has a mask register, one bit per status field. A set mask bit holds the matching status bit at zero. It also stops that condition from latching and from raising the interrupt. The one exception is the reset-event bit, which no mask bit can hide. The first channel's mask register also carries a control bit. This bit picks whether that channel's receive data is forced to ones or to zeros while loss of signal is present.

The host port is a plain strobe interface. Read data is combinational from the address during the cycle that the read strobe is high. Any clearing caused by the read takes effect at the clock edge that ends that cycle.

Top module: `latched_alarm_irq`

## Requirements
- R1: Address map. 0x10 is channel-1 status and 0x11 is channel-2 status. 0x12 is channel-1 mask and 0x13 is channel-2 mask. Masks reset to 0x00 and read back as written. Any other address reads 0x00, and writes to it have no effect.
- R2: The status layout is the same for both channels. Bit 7 is the live LOS level and bit 6 latches on a LOS rising edge. Bit 5 is the live AIS level and bit 4 latches on an AIS rising edge. An input that stays high does not latch again after a read.
- R3: Bit 3 latches on a violation pulse, but only while that channel's decoder-enable input is 1. Bit 2 latches on an overflow pulse.
- R4: After reset, channel-1 status bit 1 (reset event) reads 1 and the interrupt output is low. No mask value hides this bit, because channel-1 mask bit 1 has a different use. A channel-1 status read clears it.
- R5: Channel-2 status bit 1 latches while either the transmit-clock-lost flag or the reference-clock-lost flag is high. Channel-2 mask bit 1 masks it.
- R6: A set mask bit (7, 6, 5, 4, 3 or 2, or channel-2 bit 1) makes the matching status bit read 0. The condition it masks is not kept and does not drive the interrupt.
- R7: Status bit 0 (summary) sets when an unmasked sticky bit goes from 0 to 1, or when an unmasked live bit changes. Mask bit 0 blocks it. int_n is low when either channel's unmasked summary is set, or when the reset-event bit is set.
- R8: A status read clears bits 6, 4, 3, 2, 1 and 0 of that channel only, at the end of the read cycle. An event in the same cycle as the read wins and stays latched.
- R9: While channel-1 LOS is high, both channel-1 receive outputs equal channel-1 mask bit 1. While channel-2 LOS is high, both channel-2 receive outputs are 0. Otherwise the outputs follow their inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_addr | input | 8 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe; a status read clears that channel's sticky bits |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| los_i | input | 2 | Live loss-of-signal per channel |
| ais_i | input | 2 | Live alarm-indication per channel |
| bpv_i | input | 2 | Bipolar-violation pulse per channel |
| ovf_i | input | 2 | Waveform-overflow pulse per channel |
| dec_en_i | input | 2 | Line-decoder enable per channel |
| tclk_lost_i | input | 1 | Transmit clock absent |
| refclk_lost_i | input | 1 | Reference clock absent |
| rx_pos_i | input | 2 | Receive positive data per channel |
| rx_neg_i | input | 2 | Receive negative data per channel |
| rx_pos_o | output | 2 | Receive positive data after LOS substitution |
| rx_neg_o | output | 2 | Receive negative data after LOS substitution |
| int_n_o | output | 1 | Active-low interrupt |

## Verification
Some properties are checked on every cycle. These are: a steady AIS level does not latch again, and a violation with the decoder off never latches. An overflow that arrives during a read survives the clear, and a masked overflow is never kept. A mask write lands on the next cycle, the reset-event bit always holds int_n low, and channel-2 receive data is zero during LOS. Other behaviour needs whole read sequences, and only the bench scenarios show it. This covers the exact status byte after each event type, with and without its mask, and the live-bit change that sets the summary. It also covers isolation between the two channels, the level-held clock-loss case, and the substituted receive data values.

// File: rtl/lai_pkg.sv
package lai_pkg;
  localparam int NCH    = 2;
  localparam int REG_W  = 8;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] STAT_BASE = 8'h10;
  localparam logic [ADDR_W-1:0] MASK_BASE = 8'h12;

  localparam int B_LIVE_LOS = 7;
  localparam int B_LAT_LOS  = 6;
  localparam int B_LIVE_AIS = 5;
  localparam int B_LAT_AIS  = 4;
  localparam int B_LAT_BPV  = 3;
  localparam int B_LAT_OVF  = 2;
  localparam int B_AUX      = 1;
  localparam int B_SUM      = 0;

  localparam logic [REG_W-1:0] AUX_BIT = REG_W'(1) << B_AUX;
endpackage

// File: rtl/lai_chan.sv
module lai_chan
  import lai_pkg::*;
#(
  parameter bit HAS_RESET_LATCH = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             los_i,
  input  logic             ais_i,
  input  logic             bpv_i,
  input  logic             ovf_i,
  input  logic             dec_en_i,
  input  logic             aux_ev_i,
  input  logic [REG_W-1:0] mask_i,
  input  logic             rd_clr_i,
  output logic [REG_W-1:0] status_o,
  output logic             irq_o
);
  localparam logic [REG_W-1:0] LAT_RST = HAS_RESET_LATCH ? AUX_BIT : '0;

  logic             los_q, ais_q;
  logic [REG_W-1:0] lat_q, lat_d, set_ev;
  logic             live_chg, fresh, sum_set, lat_en;

  always_comb begin
    set_ev            = '0;
    set_ev[B_LAT_LOS] = los_i & ~los_q & ~mask_i[B_LAT_LOS];
    set_ev[B_LAT_AIS] = ais_i & ~ais_q & ~mask_i[B_LAT_AIS];
    set_ev[B_LAT_BPV] = bpv_i & dec_en_i & ~mask_i[B_LAT_BPV];
    set_ev[B_LAT_OVF] = ovf_i & ~mask_i[B_LAT_OVF];
    set_ev[B_AUX]     = aux_ev_i & ~mask_i[B_AUX];
    live_chg = ((los_i ^ los_q) & ~mask_i[B_LIVE_LOS])
             | ((ais_i ^ ais_q) & ~mask_i[B_LIVE_AIS]);
    fresh    = |(set_ev & ~lat_q);
    sum_set  = (fresh | live_chg) & ~mask_i[B_SUM];
    lat_d    = (rd_clr_i ? '0 : lat_q) | set_ev;
    lat_d[B_SUM] = (rd_clr_i ? 1'b0 : lat_q[B_SUM]) | sum_set;
    lat_en   = rd_clr_i | (|set_ev) | sum_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      los_q <= 1'b0;
      ais_q <= 1'b0;
      lat_q <= LAT_RST;
    end else begin
      los_q <= los_i;
      ais_q <= ais_i;
      if (lat_en) lat_q <= lat_d;
    end
  end

  assign status_o = ({los_i, 1'b0, ais_i, 5'b0} | lat_q) & ~mask_i;

  generate
    if (HAS_RESET_LATCH) begin : g_rst_irq
      assign irq_o = (lat_q[B_SUM] & ~mask_i[B_SUM]) | lat_q[B_AUX];
    end else begin : g_plain_irq
      assign irq_o = lat_q[B_SUM] & ~mask_i[B_SUM];
    end
  endgenerate

  assert_ais_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ais_i && ais_q && !lat_q[B_LAT_AIS]) |=> !lat_q[B_LAT_AIS]);

  assert_bpv_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bpv_i && !dec_en_i && !lat_q[B_LAT_BPV]) |=> !lat_q[B_LAT_BPV]);

  assert_masked_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_i[B_LAT_OVF] && !lat_q[B_LAT_OVF]) |=> !lat_q[B_LAT_OVF]);

  assert_event_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr_i && ovf_i && !mask_i[B_LAT_OVF]) |=> lat_q[B_LAT_OVF]);
endmodule

// File: rtl/lai_regs.sv
module lai_regs
  import lai_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic                       wr_i,
  input  logic                       rd_i,
  input  logic [REG_W-1:0]           wdata_i,
  input  logic [NCH-1:0][REG_W-1:0]  status_i,
  output logic [NCH-1:0][REG_W-1:0]  mask_o,
  output logic [NCH-1:0]             rd_clr_o,
  output logic [REG_W-1:0]           rdata_o
);
  logic [NCH-1:0] mask_we;

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_ch
      localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_BASE + g);
      localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(MASK_BASE + g);

      assign mask_we[g]  = wr_i && (addr_i == A_MASK);
      assign rd_clr_o[g] = rd_i && (addr_i == A_STAT);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mask_o[g] <= '0;
        else if (mask_we[g]) mask_o[g] <= wdata_i;
      end

      assert_mask_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == A_MASK) |=> (mask_o[g] == $past(wdata_i)));
    end
  endgenerate

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NCH; i++) begin
      if (addr_i == ADDR_W'(STAT_BASE + i)) rdata_o = status_i[i];
      if (addr_i == ADDR_W'(MASK_BASE + i)) rdata_o = mask_o[i];
    end
  end
endmodule

// File: rtl/lai_rxsub.sv
module lai_rxsub
  import lai_pkg::*;
(
  input  logic [NCH-1:0] los_i,
  input  logic           aao_i,
  input  logic [NCH-1:0] pos_i,
  input  logic [NCH-1:0] neg_i,
  output logic [NCH-1:0] pos_o,
  output logic [NCH-1:0] neg_o
);
  generate
    for (genvar g = 0; g < NCH; g++) begin : g_ch
      logic fill;
      if (g == 0) begin : g_sel
        assign fill = aao_i;
      end else begin : g_zero
        assign fill = 1'b0;
      end
      assign pos_o[g] = los_i[g] ? fill : pos_i[g];
      assign neg_o[g] = los_i[g] ? fill : neg_i[g];
    end
  endgenerate
endmodule

// File: rtl/latched_alarm_irq.sv
module latched_alarm_irq
  import lai_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic                  reg_wr,
  input  logic                  reg_rd,
  input  logic [REG_W-1:0]      reg_wdata,
  output logic [REG_W-1:0]      reg_rdata,
  input  logic [NCH-1:0]        los_i,
  input  logic [NCH-1:0]        ais_i,
  input  logic [NCH-1:0]        bpv_i,
  input  logic [NCH-1:0]        ovf_i,
  input  logic [NCH-1:0]        dec_en_i,
  input  logic                  tclk_lost_i,
  input  logic                  refclk_lost_i,
  input  logic [NCH-1:0]        rx_pos_i,
  input  logic [NCH-1:0]        rx_neg_i,
  output logic [NCH-1:0]        rx_pos_o,
  output logic [NCH-1:0]        rx_neg_o,
  output logic                  int_n_o
);
  logic [1:0]                rst_pipe;
  logic                      rst_sync_n;
  logic [NCH-1:0][REG_W-1:0] masks, status;
  logic [NCH-1:0]            rd_clr, irq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  lai_regs u_regs (
    .clk(clk), .rst_n(rst_sync_n), .addr_i(reg_addr), .wr_i(reg_wr),
    .rd_i(reg_rd), .wdata_i(reg_wdata), .status_i(status),
    .mask_o(masks), .rd_clr_o(rd_clr), .rdata_o(reg_rdata)
  );

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_chan
      logic [REG_W-1:0] mask_eff;
      logic             aux_ev;
      if (g == 0) begin : g_first
        assign mask_eff = masks[g] & ~AUX_BIT;
        assign aux_ev   = 1'b0;
      end else begin : g_other
        assign mask_eff = masks[g];
        assign aux_ev   = tclk_lost_i | refclk_lost_i;
      end
      lai_chan #(.HAS_RESET_LATCH(g == 0)) u_chan (
        .clk(clk), .rst_n(rst_sync_n), .los_i(los_i[g]), .ais_i(ais_i[g]),
        .bpv_i(bpv_i[g]), .ovf_i(ovf_i[g]), .dec_en_i(dec_en_i[g]),
        .aux_ev_i(aux_ev), .mask_i(mask_eff), .rd_clr_i(rd_clr[g]),
        .status_o(status[g]), .irq_o(irq[g])
      );
    end
  endgenerate

  lai_rxsub u_rxsub (
    .los_i(los_i), .aao_i(masks[0][B_AUX]), .pos_i(rx_pos_i),
    .neg_i(rx_neg_i), .pos_o(rx_pos_o), .neg_o(rx_neg_o)
  );

  assign int_n_o = ~(|irq);

  assert_reset_irq_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    status[0][B_AUX] |-> !int_n_o);

  assert_rx_zero_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    los_i[1] |-> (!rx_pos_o[1] && !rx_neg_o[1]));
endmodule

// File: tb/latched_alarm_irq_bench.sv
`timescale 1ns/1ps
module latched_alarm_irq_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic       reg_wr, reg_rd;
  logic [1:0] los, ais, bpv, ovf, dec_en, rxp, rxn, rxp_o, rxn_o;
  logic       tclk_lost, refclk_lost, int_n;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  latched_alarm_irq u_latched_alarm_irq (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .los_i(los), .ais_i(ais), .bpv_i(bpv), .ovf_i(ovf), .dec_en_i(dec_en),
    .tclk_lost_i(tclk_lost), .refclk_lost_i(refclk_lost),
    .rx_pos_i(rxp), .rx_neg_i(rxn), .rx_pos_o(rxp_o), .rx_neg_o(rxn_o),
    .int_n_o(int_n)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  initial begin
    logic [7:0] got;
    rst_n = 1'b0; reg_addr = '0; reg_wdata = '0; reg_wr = 0; reg_rd = 0;
    los = '0; ais = '0; bpv = '0; ovf = '0; dec_en = '0; rxp = '0; rxn = '0;
    tclk_lost = 0; refclk_lost = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R4: reset event visible, unmaskable, drives interrupt
    chk("R4 int after reset", {7'b0, int_n}, 8'h00);
    rd(8'h12, got); chk("R1 mask0 reset", got, 8'h00);
    rd(8'h13, got); chk("R1 mask1 reset", got, 8'h00);
    wr(8'h12, 8'hFF);
    rd(8'h12, got); chk("R1 mask0 readback", got, 8'hFF);
    chk("R4 int with full mask", {7'b0, int_n}, 8'h00);
    rd(8'h10, got); chk("R4 reset bit unmaskable", got, 8'h02);
    chk("R4 int cleared by read", {7'b0, int_n}, 8'h01);
    rd(8'h10, got); chk("R8 status0 cleared", got, 8'h00);
    wr(8'h12, 8'h00);
    wr(8'h20, 8'h5A);
    rd(8'h20, got); chk("R1 unmapped reads zero", got, 8'h00);
    rd(8'h12, got); chk("R1 unmapped write ignored", got, 8'h00);

    // R2 R3 R6 R8: sweep channel x event type x mask
    for (int ch = 0; ch < 2; ch++) begin
      for (int ev = 0; ev < 5; ev++) begin
        for (int mk = 0; mk < 2; mk++) begin
          logic [7:0] mb, e1, e2;
          string req;
          bit lvl;
          lvl = (ev < 2);
          case (ev)
            0: begin mb = 8'hC0; e1 = 8'hC1; e2 = 8'h80; req = "R2 los"; end
            1: begin mb = 8'h30; e1 = 8'h31; e2 = 8'h20; req = "R2 ais"; end
            2: begin mb = 8'h08; e1 = 8'h09; e2 = 8'h00; req = "R3 bpv enabled"; end
            3: begin mb = 8'h08; e1 = 8'h00; e2 = 8'h00; req = "R3 bpv decoder off"; end
            default: begin mb = 8'h04; e1 = 8'h05; e2 = 8'h00; req = "R3 ovf"; end
          endcase
          if (mk != 0) begin e1 = 8'h00; e2 = 8'h00; req = {"R6 masked ", req}; end
          wr(8'h12 + 8'(ch), (mk != 0) ? mb : 8'h00);
          dec_en[ch] = (ev == 2);
          @(negedge clk);
          case (ev)
            0: los[ch] = 1'b1;
            1: ais[ch] = 1'b1;
            2, 3: bpv[ch] = 1'b1;
            default: ovf[ch] = 1'b1;
          endcase
          @(negedge clk); bpv[ch] = 1'b0; ovf[ch] = 1'b0;
          @(negedge clk);
          chk({req, " R7 int"}, {7'b0, int_n}, (e1 != 0) ? 8'h00 : 8'h01);
          rd(8'h10 + 8'(ch), got); chk({req, " status"}, got, e1);
          chk({req, " R8 int after read"}, {7'b0, int_n}, 8'h01);
          rd(8'h10 + 8'(ch), got); chk({req, " R8 after clear"}, got, e2);
          rd(8'h10 + 8'(1 - ch), got); chk({req, " R8 other channel"}, got, 8'h00);
          if (lvl) begin
            @(negedge clk); los[ch] = 1'b0; ais[ch] = 1'b0;
            @(negedge clk);
            rd(8'h10 + 8'(ch), got);
            chk({req, " R7 live fall"}, got, (mk != 0) ? 8'h00 : 8'h01);
            rd(8'h10 + 8'(ch), got); chk({req, " R8 drained"}, got, 8'h00);
          end
          dec_en[ch] = 1'b0;
          wr(8'h12 + 8'(ch), 8'h00);
        end
      end
    end

    // R8: event in the read cycle wins
    @(negedge clk); ovf[0] = 1'b1; reg_addr = 8'h10; reg_rd = 1'b1;
    #1 got = reg_rdata; chk("R8 read before event", got, 8'h00);
    @(negedge clk); ovf[0] = 1'b0; reg_rd = 1'b0;
    rd(8'h10, got); chk("R8 event wins over clear", got, 8'h05);

    // R5: clock-loss latch
    @(negedge clk); refclk_lost = 1'b1;
    @(negedge clk);
    rd(8'h11, got); chk("R5 refclk lost", got, 8'h03);
    rd(8'h11, got); chk("R5 held level relatches", got, 8'h02);
    chk("R7 no summary on relatch", {7'b0, int_n}, 8'h01);
    refclk_lost = 1'b0;
    @(negedge clk);
    rd(8'h11, got); chk("R5 still latched", got, 8'h02);
    rd(8'h11, got); chk("R5 cleared", got, 8'h00);
    @(negedge clk); tclk_lost = 1'b1;
    @(negedge clk); tclk_lost = 1'b0;
    rd(8'h11, got); chk("R5 tclk lost", got, 8'h03);
    wr(8'h13, 8'h02);
    @(negedge clk); tclk_lost = 1'b1;
    @(negedge clk); tclk_lost = 1'b0;
    @(negedge clk);
    chk("R6 masked clk-loss int", {7'b0, int_n}, 8'h01);
    rd(8'h11, got); chk("R6 masked clk-loss", got, 8'h00);
    wr(8'h13, 8'h00);

    // R7: interrupt OR across channels and summary mask
    @(negedge clk); ovf[1] = 1'b1;
    @(negedge clk); ovf[1] = 1'b0;
    chk("R7 ch2 drives int", {7'b0, int_n}, 8'h00);
    rd(8'h10, got); chk("R7 ch1 quiet", got, 8'h00);
    chk("R7 int held by ch2", {7'b0, int_n}, 8'h00);
    rd(8'h11, got); chk("R7 ch2 status", got, 8'h05);
    chk("R7 int released", {7'b0, int_n}, 8'h01);
    wr(8'h12, 8'h01);
    @(negedge clk); ovf[0] = 1'b1;
    @(negedge clk); ovf[0] = 1'b0;
    chk("R7 summary masked int", {7'b0, int_n}, 8'h01);
    rd(8'h10, got); chk("R7 summary masked status", got, 8'h04);
    wr(8'h12, 8'h00);

    // R9: receive data substitution
    @(negedge clk); rxp = 2'b11; rxn = 2'b10; #1;
    chk("R9 pass pos", {6'b0, rxp_o}, 8'h03);
    chk("R9 pass neg", {6'b0, rxn_o}, 8'h02);
    los = 2'b11; #1;
    chk("R9 zeros pos", {6'b0, rxp_o}, 8'h00);
    chk("R9 zeros neg", {6'b0, rxn_o}, 8'h00);
    wr(8'h12, 8'h02); #1;
    chk("R9 ones pos", {6'b0, rxp_o}, 8'h01);
    chk("R9 ones neg", {6'b0, rxn_o}, 8'h01);
    @(negedge clk); los = 2'b00;
    @(negedge clk);
    rd(8'h10, got); rd(8'h10, got); chk("R8 drain ch1", got, 8'h00);
    rd(8'h11, got); rd(8'h11, got); chk("R8 drain ch2", got, 8'h00);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule